// File: doc/BRIEF.md
# Multicycle 16-bit Register-Machine Core

This block is a compact processor core in which a finite state machine moves every 16-bit instruction through fetch, decode, address calculation, operand fetch, execute and write-back. Eight 16-bit general registers feed a small ALU. A program counter, an instruction register, a memory address register and a memory data register form the rest of the datapath. Every memory access passes through the address and data registers, each step in its own control state.

The core drives one word-addressed, single-port memory with separate read and write strobes. Read data must come back one cycle after the read strobe. The instruction subset is add, bitwise and, base-plus-offset load and store, register-indirect jump, flag-conditional relative branch and halt. Any other opcode does nothing. Once a halt instruction is decoded, the core freezes, and software inspects the results in memory.

Top module: `mcpu16_core`

## Requirements
- R1: While reset is low, neither strobe is asserted and the address output is 0. After reset the PC, all registers and the flags are cleared except Z, which is 1. The first read strobe, to address 0, is asserted one cycle after reset is released.
- R2: Fetch places the PC on the address output with a one-cycle read strobe. It takes the returned word as the instruction and advances the PC by one. Consecutive non-control instructions are read from consecutive addresses.
- R3: Add (opcode 0001) and and (opcode 0101) write the destination IR[11:9] with IR[8:6] op B. B is the register IR[2:0] when IR[5]=0. When IR[5]=1, B is IR[4:0] sign-extended.
- R4: Load (opcode 0110) reads memory at register IR[8:6] plus sign-extended IR[5:0] and writes the word to register IR[11:9].
- R5: Store (opcode 0111) writes register IR[11:9] to memory at register IR[8:6] plus sign-extended IR[5:0]. The write strobe lasts one cycle and is never asserted together with the read strobe.
- R6: Jump (opcode 1100) sets the PC to register IR[8:6] without any condition.
- R7: Branch (opcode 0000) adds sign-extended IR[8:0] to the incremented PC when the mask IR[11:9] (bit 11 = N, bit 10 = Z, bit 9 = P) shares a set bit with the flags. Otherwise, and always for mask 000, the PC stays incremented.
- R8: Exactly one of the flags N, Z and P is set at any time. The flags follow the sign and zero state of the value written by add, and and load, and no other instruction changes them.
- R9: Halt (opcode 1111) stops the core. The halted output then stays high, and no strobe is asserted again until reset.
- R10: Opcodes with no defined meaning change no register, flag or memory word, and execution continues at the next address.
- R11: Fetch plus decode takes 5 cycles. Add and and take 7, load 9, store 8, branch and jump 6, an undefined opcode 5, and halt reaches the halted state 5 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address, driven from the memory address register |
| mem_rd | output | 1 | Read strobe; data is due on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Store data, driven from the memory data register |
| mem_rdata | input | 16 | Read data, valid the cycle after mem_rd |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
Each instruction costs a fixed number of cycles counted from the start of its fetch. The bench therefore counts clock edges from reset release and predicts the exact edge for several events. The first read strobe must appear after edge 1 and the second instruction fetch after edge 8. The halted output must rise after edge 260 of the test program. Store results are checked by a scoreboard rather than at fixed times. The expected address and data pairs are queued in program order, and a monitor compares each write strobe at the falling edge following the cycle it appears in. A write that arrives when the queue is empty counts as a mismatch. After halt, the bench watches the strobes for a further stretch and then compares every memory word with its predicted image.

// File: rtl/mcpu16_pkg.sv
package mcpu16_pkg;

  localparam int XLEN = 16;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FREAD, ST_FLATCH, ST_FIR, ST_DECODE,
    ST_EVAL, ST_MREAD, ST_MLATCH, ST_EXEC, ST_WBACK,
    ST_SDATA, ST_SWRITE, ST_BRANCH, ST_JUMP, ST_HALT
  } cpu_state_e;

  localparam logic [3:0] OP_BR   = 4'h0;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_LDR  = 4'h6;
  localparam logic [3:0] OP_STR  = 4'h7;
  localparam logic [3:0] OP_JMP  = 4'hC;
  localparam logic [3:0] OP_HALT = 4'hF;

  localparam logic [15:0] KNOWN_OPS = (16'h1 << OP_BR) | (16'h1 << OP_ADD) |
                                      (16'h1 << OP_AND) | (16'h1 << OP_LDR) |
                                      (16'h1 << OP_STR) | (16'h1 << OP_JMP) |
                                      (16'h1 << OP_HALT);

  // replicate bit nbits-1 of raw into every higher position
  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] raw, input int nbits);
    logic [XLEN-1:0] r;
    r = raw;
    for (int i = 0; i < XLEN; i++) begin
      if (i >= nbits) r[i] = raw[nbits-1];
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] alu_calc(input logic do_and,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return do_and ? (a & b) : (a + b);
  endfunction

  // {N, Z, P}
  function automatic logic [2:0] flags_of(input logic [XLEN-1:0] v);
    if (v[XLEN-1])   return 3'b100;
    else if (v == 0) return 3'b010;
    else             return 3'b001;
  endfunction

endpackage

// File: rtl/mcpu16_regfile.sv
module mcpu16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mcpu16_flags.sv
module mcpu16_flags
  import mcpu16_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [XLEN-1:0] result,
  output logic [2:0]      nzp
);
  always_ff @(posedge clk) begin
    if (!rst_n)  nzp <= 3'b010;
    else if (ld) nzp <= flags_of(result);
  end

  // R8
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nzp) == 1);

  // R8
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(nzp));
endmodule

// File: rtl/mcpu16_ctrl.sv
module mcpu16_ctrl
  import mcpu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  input  logic       br_take,
  output logic       ld_mar_pc,
  output logic       mem_rd,
  output logic       ld_mdr_mem,
  output logic       ld_ir,
  output logic       pc_inc,
  output logic       ld_mar_ea,
  output logic       ld_mdr_reg,
  output logic       mem_wr,
  output logic       ld_res,
  output logic       rf_we,
  output logic       cc_ld,
  output logic       pc_br,
  output logic       pc_jmp,
  output logic       wb_mem,
  output logic       halted
);
  cpu_state_e state, nxt;
  logic [15:0] dec;
  logic        op_unknown;

  // one-hot 4-to-16 opcode decoder
  for (genvar k = 0; k < 16; k++) begin : g_dec
    assign dec[k] = (opcode == 4'(k));
  end

  assign op_unknown = |(dec & ~KNOWN_OPS);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FADDR:  nxt = ST_FREAD;
      ST_FREAD:  nxt = ST_FLATCH;
      ST_FLATCH: nxt = ST_FIR;
      ST_FIR:    nxt = ST_DECODE;
      ST_DECODE: begin
        if (op_unknown)                    nxt = ST_FADDR;
        else if (dec[OP_ADD] | dec[OP_AND]) nxt = ST_EXEC;
        else if (dec[OP_LDR] | dec[OP_STR]) nxt = ST_EVAL;
        else if (dec[OP_BR])               nxt = ST_BRANCH;
        else if (dec[OP_JMP])              nxt = ST_JUMP;
        else                               nxt = ST_HALT;
      end
      ST_EVAL:   nxt = dec[OP_LDR] ? ST_MREAD : ST_SDATA;
      ST_MREAD:  nxt = ST_MLATCH;
      ST_MLATCH: nxt = ST_WBACK;
      ST_EXEC:   nxt = ST_WBACK;
      ST_WBACK:  nxt = ST_FADDR;
      ST_SDATA:  nxt = ST_SWRITE;
      ST_SWRITE: nxt = ST_FADDR;
      ST_BRANCH: nxt = ST_FADDR;
      ST_JUMP:   nxt = ST_FADDR;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FADDR;
    else        state <= nxt;
  end

  assign ld_mar_pc  = (state == ST_FADDR);
  assign mem_rd     = (state == ST_FREAD) | (state == ST_MREAD);
  assign ld_mdr_mem = (state == ST_FLATCH) | (state == ST_MLATCH);
  assign ld_ir      = (state == ST_FIR);
  assign pc_inc     = (state == ST_FIR);
  assign ld_mar_ea  = (state == ST_EVAL);
  assign ld_mdr_reg = (state == ST_SDATA);
  assign mem_wr     = (state == ST_SWRITE);
  assign ld_res     = (state == ST_EXEC);
  assign rf_we      = (state == ST_WBACK);
  assign cc_ld      = (state == ST_WBACK);
  assign pc_br      = (state == ST_BRANCH) & br_take;
  assign pc_jmp     = (state == ST_JUMP);
  assign wb_mem     = dec[OP_LDR];
  assign halted     = (state == ST_HALT);

  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |-> $past(mem_rd, 2));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));
endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
  import mcpu16_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        halted
);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc, ir, mar, mdr, res_q;
  logic [XLEN-1:0] rdata_a, rdata_b, opnd_b, alu_out, eff_addr, br_target, wb_data;
  logic [RAW-1:0]  raddr_b;
  logic [2:0]      nzp;
  logic            br_take;
  logic ld_mar_pc, ld_mdr_mem, ld_ir, pc_inc, ld_mar_ea, ld_mdr_reg;
  logic ld_res, rf_we, cc_ld, pc_br, pc_jmp, wb_mem;

  mcpu16_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (ir[15:12]),
    .br_take    (br_take),
    .ld_mar_pc  (ld_mar_pc),
    .mem_rd     (mem_rd),
    .ld_mdr_mem (ld_mdr_mem),
    .ld_ir      (ld_ir),
    .pc_inc     (pc_inc),
    .ld_mar_ea  (ld_mar_ea),
    .ld_mdr_reg (ld_mdr_reg),
    .mem_wr     (mem_wr),
    .ld_res     (ld_res),
    .rf_we      (rf_we),
    .cc_ld      (cc_ld),
    .pc_br      (pc_br),
    .pc_jmp     (pc_jmp),
    .wb_mem     (wb_mem),
    .halted     (halted)
  );

  // store data comes from the destination field, everything else from IR[2:0]
  assign raddr_b = ld_mdr_reg ? ir[11:9] : ir[2:0];

  mcpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (ir[11:9]),
    .wdata   (wb_data),
    .raddr_a (ir[8:6]),
    .rdata_a (rdata_a),
    .raddr_b (raddr_b),
    .rdata_b (rdata_b)
  );

  assign opnd_b    = ir[5] ? sext({11'b0, ir[4:0]}, 5) : rdata_b;
  assign alu_out   = alu_calc(ir[15:12] == OP_AND, rdata_a, opnd_b);
  assign eff_addr  = rdata_a + sext({10'b0, ir[5:0]}, 6);
  assign br_target = pc + sext({7'b0, ir[8:0]}, 9);
  assign br_take   = |(ir[11:9] & nzp);
  assign wb_data   = wb_mem ? mdr : res_q;

  mcpu16_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (cc_ld),
    .result (wb_data),
    .nzp    (nzp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      ir    <= '0;
      mar   <= '0;
      mdr   <= '0;
      res_q <= '0;
    end else begin
      if (pc_inc)      pc <= pc + 1'b1;
      else if (pc_br)  pc <= br_target;
      else if (pc_jmp) pc <= rdata_a;

      if (ld_mar_pc)      mar <= pc;
      else if (ld_mar_ea) mar <= eff_addr;

      if (ld_mdr_mem)      mdr <= mem_rdata;
      else if (ld_mdr_reg) mdr <= rdata_b;

      if (ld_ir)  ir    <= mdr;
      if (ld_res) res_q <= alu_out;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

// File: tb/sim_mcpu16_core.sv
`timescale 1ns/1ps
module sim_mcpu16_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mcpu16_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  // ---------------- encoders ----------------
  function automatic logic [15:0] e_rr(logic [3:0] op, logic [2:0] d, logic [2:0] s1, logic [2:0] s2);
    return {op, d, s1, 3'b000, s2};
  endfunction
  function automatic logic [15:0] e_ri(logic [3:0] op, logic [2:0] d, logic [2:0] s1, logic [4:0] imm);
    return {op, d, s1, 1'b1, imm};
  endfunction
  function automatic logic [15:0] e_mem(logic [3:0] op, logic [2:0] r, logic [2:0] b, logic [5:0] off);
    return {op, r, b, off};
  endfunction
  function automatic logic [15:0] e_br(logic [2:0] nzp, logic [8:0] off);
    return {4'h0, nzp, off};
  endfunction
  function automatic logic [15:0] e_jmp(logic [2:0] b);
    return {4'hC, 3'b000, b, 6'b000000};
  endfunction

  function automatic logic [15:0] prog_word(int a);
    case (a)
      0:  return e_ri(4'h1, 3'd1, 3'd0, 5'd5);      // R1 = 5
      1:  return e_ri(4'h1, 3'd2, 3'd1, 5'h1D);     // R2 = R1 - 3 = 2
      2:  return e_rr(4'h1, 3'd3, 3'd1, 3'd2);      // R3 = 7
      3:  return e_ri(4'h5, 3'd4, 3'd3, 5'h1E);     // R4 = 7 & -2 = 6
      4:  return e_rr(4'h5, 3'd5, 3'd3, 3'd2);      // R5 = 7 & 2 = 2
      5:  return e_ri(4'h1, 3'd7, 3'd0, 5'd15);     // R7 = 15
      6:  return e_mem(4'h6, 3'd6, 3'd7, 6'd20);    // R6 = mem[35]
      7:  return e_br(3'b100, 9'd1);                // taken, skip 8
      8:  return e_ri(4'h1, 3'd6, 3'd0, 5'd1);
      9:  return e_br(3'b010, 9'd1);                // not taken
      10: return e_mem(4'h7, 3'd6, 3'd7, 6'd21);
      11: return e_mem(4'h7, 3'd1, 3'd7, 6'd22);
      12: return e_mem(4'h7, 3'd2, 3'd7, 6'd23);
      13: return e_mem(4'h7, 3'd3, 3'd7, 6'd24);
      14: return e_mem(4'h7, 3'd4, 3'd7, 6'd25);
      15: return e_mem(4'h7, 3'd5, 3'd7, 6'd26);
      16: return e_ri(4'h1, 3'd1, 3'd7, 5'd5);      // R1 = 20
      17: return e_jmp(3'd1);
      18, 19, 23: return e_mem(4'h7, 3'd1, 3'd7, 6'd27); // must be skipped
      20: return e_mem(4'h6, 3'd2, 3'd7, 6'd17);    // R2 = mem[32] = 0
      21: return e_br(3'b101, 9'd1);                // not taken
      22: return e_br(3'b010, 9'd1);                // taken, skip 23
      24: return e_mem(4'h6, 3'd3, 3'd7, 6'h3F);    // R3 = mem[14]
      25: return e_mem(4'h7, 3'd3, 3'd7, 6'd28);
      26: return e_ri(4'h5, 3'd4, 3'd4, 5'd0);      // R4 = 0
      27: return e_ri(4'h1, 3'd5, 3'd0, 5'd3);      // R5 = 3
      28: return e_ri(4'h1, 3'd4, 3'd4, 5'd2);
      29: return e_ri(4'h1, 3'd5, 3'd5, 5'h1F);
      30: return e_br(3'b001, 9'h1FD);              // back to 28
      31: return e_mem(4'h7, 3'd4, 3'd7, 6'd29);
      33: return 16'hD000;                          // undefined opcode
      34: return 16'hF000;
      35: return 16'h8001;
      default: return 16'h0000;                     // 32: branch with empty mask
    endcase
  endfunction

  function automatic logic [15:0] final_word(int a);
    case (a)
      36: return 16'h8001;
      37: return 16'd5;
      38: return 16'd2;
      39: return 16'd7;
      40: return 16'd6;
      41: return 16'd2;
      43: return prog_word(14);
      44: return 16'd6;
      default: return prog_word(a);
    endcase
  endfunction

  // ---------------- memory model (one-cycle read latency) ----------------
  logic [15:0] mem [0:255];
  logic [15:0] rdq;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= prog_word(i);
      rdq <= '0;
    end else begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) rdq <= mem[mem_addr[7:0]];
    end
  end
  assign mem_rdata = rdq;

  // ---------------- checking ----------------
  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic push_write(logic [15:0] a, logic [15:0] d, string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor: every write strobe is compared with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected write", {mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({mem_addr, mem_wdata} == e, t, "store addr/data", {mem_addr, mem_wdata}, e);
      end
    end
  end

  initial begin
    int cyc;
    int bad_hold;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);
    check(mem_addr == 16'h0, "R1", "address in reset", mem_addr, 0);
    check(!halted, "R1", "halted in reset", halted, 0);

    push_write(16'd36, 16'h8001, "R4_R7_R8");   // load negative, BRn taken
    push_write(16'd37, 16'd5,    "R3");
    push_write(16'd38, 16'd2,    "R3");
    push_write(16'd39, 16'd7,    "R3");
    push_write(16'd40, 16'd6,    "R3");
    push_write(16'd41, 16'd2,    "R3");
    push_write(16'd43, prog_word(14), "R4");    // negative offset load
    push_write(16'd44, 16'd6,    "R7");         // backward branch loop

    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1)
        check(mem_rd && mem_addr == 16'd0, "R1", "first read", {mem_rd, mem_addr}, {1'b1, 16'd0});
      if (cyc == 8)
        check(mem_rd && mem_addr == 16'd1, "R2", "second fetch", {mem_rd, mem_addr}, {1'b1, 16'd1});
    end
    if (!halted) check(1'b0, "R9", "watchdog expired", cyc, 260);
    // R11 total cycle budget of the program
    check(cyc == 260, "R11", "cycles to halt", cyc, 260);
    check(exp_q.size() == 0, "R5", "pending writes", exp_q.size(), 0);

    bad_hold = 0;
    repeat (20) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) bad_hold++;
    end
    check(bad_hold == 0, "R9", "activity after halt", bad_hold, 0);

    // R6 R7 R10: skipped words leave address 42 unwritten; all words as predicted
    for (int a = 0; a < 64; a++)
      check(mem[a] == final_word(a), "R10", $sformatf("mem[%0d]", a), mem[a], final_word(a));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule